// File: doc/BRIEF.md
# Debug Port Transaction Sequencer

This block runs one bus transaction at a time through a small debug port. A host side gives a command with an operation, a device address, an endpoint, a length of up to eight bytes and an eight-byte payload. The sequencer then prepares the 24-bit PID word and raises a one-cycle go strobe toward a bus-side transaction model. It waits for that model's done pulse and reports one result: a signed status and, for a read, the bytes it received.

Several recovery rules live inside the sequencer. A NAK handshake makes it reissue the same transaction. A bus error on a write makes it send dummy packets to bring the data toggle back in step, then retry the write. If no response comes within a fixed poll window, it reports a timeout and latches an unsafe flag. That flag refuses every later command until the next reset. Line signalling, CRC and the serial engine belong to the bus model and are not part of this block.

Top module: `dbg_txn_seq`

## Requirements
- R1: After reset the block is idle: busy, res_valid, bus_go and unsafe are 0. The first non-setup transaction after reset carries data PID 0xC3 in bus_pid[15:8].
- R2: A start with cmd_op 3, or with cmd_op 0 or 1 and cmd_len above 8, gets status -1 (0xFF). No bus_go is raised for it.
- R3: Operation 0 (write) drives token 0xE1 in bus_pid[7:0] with bus_out 1. Operation 1 (read) drives token 0x69 with bus_out 0. Each new non-setup transaction XORs bus_pid[23:8] with 0x0088, so the data PID in bits 15:8 alternates between 0xC3 and 0x4B.
- R4: Operation 2 (setup) drives token 0x2D and data PID 0xC3. It forces bus_pid[23:16] to 0, endpoint 0 and length 8. It sends all eight bytes of cmd_wdata and ignores cmd_len. A successful setup reports status 8.
- R5: A response with no error and handshake PID 0x5A is reissued with bus_pid[15:0] unchanged. At most 3 attempts are made. If the last attempt is also a NAK, its result is reported as a normal success.
- R6: If no done pulse arrives within TIMEOUT_CYCLES cycles of a go, the block reports status -3 (0xFD) and sets unsafe. Unsafe stays set until reset. While it is set, every start gets status -2 (0xFE) and causes no bus activity.
- R7: A bus error with 3-bit code c reports status -(8+c) with res_data 0. Reads and setups never start a resync.
- R8: On a write, error code 1 starts a resync. The block sends dummy writes of 8 bytes of DUMMY_PATTERN, each a new toggled transaction. A dummy counts as good if it ends without error (a final NAK counts as good). After a good dummy the real write is sent again. The block allows at most 3 dummies per resync and at most 5 real attempts. When either limit is exhausted it reports -9.
- R9: A successful write reports cmd_len with res_data 0. A successful read reports the received length bus_rlen. Its res_data holds the low min(cmd_len, bus_rlen) bytes of bus_rdata, and every other byte is 0.
- R10: Only one transaction is outstanding. bus_go lasts one cycle. A start while busy is ignored. Each accepted or refused command gives exactly one res_valid pulse, one cycle long.
- R11: bus_wdata is little-endian: byte k of cmd_wdata sits in bits 8k+7:8k. Bytes at or beyond the write length are 0. bus_pid[23:16] holds the handshake PID of the last completed response. It is 0 after reset or at the first attempt of a setup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 write, 1 read, 2 setup, 3 refused |
| cmd_len | input | 4 | Requested byte count |
| cmd_dev | input | 7 | Device address |
| cmd_ep | input | 4 | Endpoint number |
| cmd_wdata | input | 64 | Payload, byte 0 in bits 7:0 |
| busy | output | 1 | Command in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_status | output | 8 | Signed length or negative error |
| res_data | output | 64 | Read bytes, zero-filled |
| unsafe | output | 1 | Sticky flag after a poll timeout |
| bus_go | output | 1 | One-cycle transaction start |
| bus_out | output | 1 | 1 for host-to-device data |
| bus_dev | output | 7 | Target device |
| bus_ep | output | 4 | Target endpoint |
| bus_len | output | 4 | Byte count of this transaction |
| bus_pid | output | 24 | Handshake, data PID and token bytes |
| bus_wdata | output | 64 | Outgoing payload |
| bus_done | input | 1 | Response pulse |
| bus_err | input | 1 | Response carries an error |
| bus_err_code | input | 3 | Error code |
| bus_hs_pid | input | 8 | Returned handshake PID |
| bus_rlen | input | 4 | Received byte count |
| bus_rdata | input | 64 | Received bytes |

## Verification
Some properties can be checked on every cycle, and the checker does so. These are the go and result strobes being single-cycle, the length cap at the bus edge, the token and direction pairing, the fixed setup format, the stickiness of unsafe with no bus activity while it is set, and zero data with any negative status. Other behaviour depends on how a sequence of responses plays out, and only the bench's scripted responder can show it. This covers NAK reissue limits, the dummy-and-retry counts, the toggle alternating across reissues and resyncs, the byte masking of read data, and the handshake byte carried into the next PID word.

// File: rtl/dbg_txn_seq.sv
module dbg_txn_seq #(
  parameter int          TIMEOUT_CYCLES = 250000,
  parameter int          NAK_TRIES      = 3,
  parameter int          WRITE_TRIES    = 5,
  parameter int          RESYNC_TRIES   = 3,
  parameter logic [63:0] DUMMY_PATTERN  = 64'h3837_3635_3433_3231
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  cmd_op,
  input  logic [3:0]  cmd_len,
  input  logic [6:0]  cmd_dev,
  input  logic [3:0]  cmd_ep,
  input  logic [63:0] cmd_wdata,
  output logic        busy,
  output logic        res_valid,
  output logic [7:0]  res_status,
  output logic [63:0] res_data,
  output logic        unsafe,
  output logic        bus_go,
  output logic        bus_out,
  output logic [6:0]  bus_dev,
  output logic [3:0]  bus_ep,
  output logic [3:0]  bus_len,
  output logic [23:0] bus_pid,
  output logic [63:0] bus_wdata,
  input  logic        bus_done,
  input  logic        bus_err,
  input  logic [2:0]  bus_err_code,
  input  logic [7:0]  bus_hs_pid,
  input  logic [3:0]  bus_rlen,
  input  logic [63:0] bus_rdata
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int NW = $clog2(NAK_TRIES + 1);
  localparam int WW = $clog2(WRITE_TRIES + 1);
  localparam int DW = $clog2(RESYNC_TRIES + 1);

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SU = 2'd2;
  localparam logic [7:0] TOK_WR = 8'hE1, TOK_RD = 8'h69, TOK_SU = 8'h2D;
  localparam logic [7:0] DPID0 = 8'hC3, HS_NAK = 8'h5A, FLIP = 8'h88;
  localparam logic [7:0] ST_REJECT = 8'hFF, ST_UNSAFE = 8'hFE, ST_TMO = 8'hFD;
  localparam logic [7:0] ST_BAD = 8'hF7, ST_ERR0 = 8'hF8;

  typedef enum logic [1:0] {S_IDLE, S_GO, S_WAIT} state_t;
  typedef enum logic [2:0] {A_NONE, A_FIN, A_TMO, A_START, A_AGAIN, A_REAL, A_DUMMY} act_t;

  state_t      st;
  act_t        act;
  logic [1:0]  op_q;
  logic [3:0]  len_q;
  logic [6:0]  dev_q;
  logic [3:0]  ep_q;
  logic [63:0] wdata_q;
  logic [23:0] pid_q;
  logic        dummy_q, unsafe_q;
  logic [NW-1:0] nak_cnt;
  logic [WW-1:0] real_cnt;
  logic [DW-1:0] dum_cnt;
  logic [TW-1:0] tmo_cnt;
  logic [7:0]  fin_st;
  logic [63:0] fin_dat;
  logic [3:0]  nkeep;
  logic        is_nak;

  function automatic logic [63:0] keep_bytes(input logic [63:0] d, input logic [3:0] n);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = (4'(i) < n) ? d[8*i +: 8] : 8'h00;
    return r;
  endfunction

  assign is_nak = !bus_err && (bus_hs_pid == HS_NAK);
  assign nkeep  = (bus_rlen < len_q) ? bus_rlen : len_q;

  always_comb begin
    act     = A_NONE;
    fin_st  = 8'h00;
    fin_dat = 64'h0;
    case (st)
      S_IDLE: if (start) begin
        if (unsafe_q) begin
          act = A_FIN; fin_st = ST_UNSAFE;
        end else if (cmd_op == 2'd3 || (cmd_op != OP_SU && cmd_len > 4'd8)) begin
          act = A_FIN; fin_st = ST_REJECT;
        end else begin
          act = A_START;
        end
      end
      S_WAIT: if (bus_done) begin
        if (is_nak && nak_cnt < NW'(NAK_TRIES - 1)) begin
          act = A_AGAIN;
        end else if (dummy_q) begin
          if (!bus_err) act = A_REAL;
          else if (dum_cnt < DW'(RESYNC_TRIES - 1)) act = A_DUMMY;
          else begin act = A_FIN; fin_st = ST_BAD; end
        end else if (bus_err && op_q == OP_WR && bus_err_code == 3'd1 &&
                     real_cnt < WW'(WRITE_TRIES - 1)) begin
          act = A_DUMMY;
        end else if (bus_err) begin
          act = A_FIN; fin_st = ST_ERR0 - {5'b0, bus_err_code};
        end else begin
          act = A_FIN;
          if (op_q == OP_RD) begin
            fin_st  = {4'b0, bus_rlen};
            fin_dat = keep_bytes(bus_rdata, nkeep);
          end else begin
            fin_st = (op_q == OP_SU) ? 8'd8 : {4'b0, len_q};
          end
        end
      end else if (tmo_cnt == TW'(TIMEOUT_CYCLES - 1)) begin
        act = A_TMO;
      end
      default: act = A_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_WR; len_q <= '0; dev_q <= '0; ep_q <= '0;
      wdata_q <= '0; pid_q <= {8'h00, DPID0 ^ FLIP, 8'h00};
      dummy_q <= 1'b0; unsafe_q <= 1'b0;
      nak_cnt <= '0; real_cnt <= '0; dum_cnt <= '0; tmo_cnt <= '0;
      res_valid <= 1'b0; res_status <= '0; res_data <= '0;
    end else begin
      res_valid <= 1'b0;
      if (st == S_GO) begin
        st <= S_WAIT; tmo_cnt <= '0;
      end else if (st == S_WAIT) begin
        tmo_cnt <= tmo_cnt + 1'b1;
      end
      if (st == S_WAIT && bus_done) pid_q[23:16] <= bus_hs_pid;
      case (act)
        A_FIN: begin
          res_valid <= 1'b1; res_status <= fin_st; res_data <= fin_dat; st <= S_IDLE;
        end
        A_TMO: begin
          res_valid <= 1'b1; res_status <= ST_TMO; res_data <= '0;
          unsafe_q <= 1'b1; st <= S_IDLE;
        end
        A_START: begin
          op_q <= cmd_op; len_q <= cmd_len; dev_q <= cmd_dev; ep_q <= cmd_ep;
          wdata_q <= (cmd_op == OP_SU) ? cmd_wdata : keep_bytes(cmd_wdata, cmd_len);
          dummy_q <= 1'b0; nak_cnt <= '0; real_cnt <= '0; dum_cnt <= '0;
          if (cmd_op == OP_SU) pid_q <= {8'h00, DPID0, TOK_SU};
          else pid_q[15:0] <= {pid_q[15:8] ^ FLIP, (cmd_op == OP_RD) ? TOK_RD : TOK_WR};
          st <= S_GO;
        end
        A_AGAIN: begin
          nak_cnt <= nak_cnt + 1'b1; st <= S_GO;
        end
        A_REAL: begin
          dummy_q <= 1'b0; real_cnt <= real_cnt + 1'b1; nak_cnt <= '0;
          pid_q[15:0] <= {pid_q[15:8] ^ FLIP, TOK_WR}; st <= S_GO;
        end
        A_DUMMY: begin
          dum_cnt <= dummy_q ? dum_cnt + 1'b1 : '0;
          dummy_q <= 1'b1; nak_cnt <= '0;
          pid_q[15:0] <= {pid_q[15:8] ^ FLIP, TOK_WR}; st <= S_GO;
        end
        default: ;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign unsafe    = unsafe_q;
  assign bus_go    = (st == S_GO);
  assign bus_out   = (op_q != OP_RD);
  assign bus_dev   = dev_q;
  assign bus_ep    = (op_q == OP_SU) ? 4'd0 : ep_q;
  assign bus_len   = (dummy_q || op_q == OP_SU) ? 4'd8 : len_q;
  assign bus_pid   = pid_q;
  assign bus_wdata = dummy_q ? DUMMY_PATTERN : wdata_q;
endmodule

// File: rtl/dbg_txn_seq_chk.sv
module dbg_txn_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        res_valid,
  input logic [7:0]  res_status,
  input logic [63:0] res_data,
  input logic        unsafe,
  input logic        bus_go,
  input logic        bus_out,
  input logic [3:0]  bus_ep,
  input logic [3:0]  bus_len,
  input logic [23:0] bus_pid
);
  p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_go |-> bus_len <= 4'd8);

  p_token_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_go |-> ((bus_pid[7:0] == 8'hE1 && bus_out) ||
                (bus_pid[7:0] == 8'h69 && !bus_out) ||
                (bus_pid[7:0] == 8'h2D && bus_out)));

  p_setup_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_go && bus_pid[7:0] == 8'h2D) |-> (bus_pid[15:8] == 8'hC3 && bus_ep == 4'd0 && bus_len == 4'd8));

  p_unsafe_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unsafe |=> unsafe);

  p_unsafe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unsafe |-> !bus_go);

  p_err_nodata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status[7]) |-> res_data == 64'h0);

  p_go_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_go |=> !bus_go);

  p_go_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_go |-> busy);

  p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind dbg_txn_seq dbg_txn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .res_valid(res_valid),
  .res_status(res_status), .res_data(res_data), .unsafe(unsafe),
  .bus_go(bus_go), .bus_out(bus_out), .bus_ep(bus_ep), .bus_len(bus_len),
  .bus_pid(bus_pid)
);

// File: tb/dbg_txn_seq_bench.sv
module dbg_txn_seq_bench;
  localparam int          TMO   = 40;
  localparam logic [63:0] PAT   = 64'hA55A_0F0F_3C3C_9696;
  localparam logic [63:0] RDATA = 64'h8877_6655_4433_2211;
  // kinds: 0 ACK, 1 NAK, 2 error code 1, 3 error code 5, 4 silent
  // fields: op, len, rlen, script (nibble 0 first), status, go count
  localparam int NV = 19;
  localparam logic [69:0] VEC [NV] = '{
    {2'd0, 4'd4, 4'd0, 48'h0,         8'h04, 4'd1},
    {2'd1, 4'd8, 4'd5, 48'h0,         8'h05, 4'd1},
    {2'd1, 4'd3, 4'd6, 48'h0,         8'h06, 4'd1},
    {2'd2, 4'd0, 4'd0, 48'h0,         8'h08, 4'd1},
    {2'd0, 4'd2, 4'd0, 48'h01,        8'h02, 4'd2},
    {2'd0, 4'd1, 4'd0, 48'h111,       8'h01, 4'd3},
    {2'd1, 4'd4, 4'd4, 48'h011,       8'h04, 4'd3},
    {2'd1, 4'd2, 4'd2, 48'h3,         8'hF3, 4'd1},
    {2'd0, 4'd8, 4'd0, 48'h002,       8'h08, 4'd3},
    {2'd0, 4'd3, 4'd0, 48'h2222,      8'hF7, 4'd4},
    {2'd0, 4'd5, 4'd0, 48'h202020202, 8'hF7, 4'd9},
    {2'd0, 4'd6, 4'd0, 48'h3,         8'hF3, 4'd1},
    {2'd0, 4'd4, 4'd0, 48'h0012,      8'h04, 4'd4},
    {2'd2, 4'd5, 4'd0, 48'h3,         8'hF3, 4'd1},
    {2'd0, 4'd9, 4'd0, 48'h0,         8'hFF, 4'd0},
    {2'd1, 4'd15,4'd0, 48'h0,         8'hFF, 4'd0},
    {2'd0, 4'd7, 4'd0, 48'h01112,     8'h07, 4'd5},
    {2'd0, 4'd6, 4'd0, 48'h0032,      8'h06, 4'd4},
    {2'd3, 4'd2, 4'd0, 48'h0,         8'hFF, 4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  c_op = '0;
  logic [3:0]  c_len = '0, c_ep = '0;
  logic [6:0]  c_dev = '0;
  logic [63:0] c_wdata = '0;
  logic        busy, res_valid, unsafe, bus_go, bus_out;
  logic [7:0]  res_status;
  logic [63:0] res_data, bus_wdata;
  logic [6:0]  bus_dev;
  logic [3:0]  bus_ep, bus_len;
  logic [23:0] bus_pid;
  logic        bus_done = 1'b0, bus_err = 1'b0;
  logic [2:0]  bus_err_code = '0;
  logic [7:0]  bus_hs_pid = '0;
  logic [3:0]  bus_rlen = '0;
  logic [63:0] bus_rdata = '0;

  dbg_txn_seq #(.TIMEOUT_CYCLES(TMO), .DUMMY_PATTERN(PAT)) u_dbg_txn_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(c_op), .cmd_len(c_len),
    .cmd_dev(c_dev), .cmd_ep(c_ep), .cmd_wdata(c_wdata), .busy(busy),
    .res_valid(res_valid), .res_status(res_status), .res_data(res_data),
    .unsafe(unsafe), .bus_go(bus_go), .bus_out(bus_out), .bus_dev(bus_dev),
    .bus_ep(bus_ep), .bus_len(bus_len), .bus_pid(bus_pid), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_err(bus_err), .bus_err_code(bus_err_code),
    .bus_hs_pid(bus_hs_pid), .bus_rlen(bus_rlen), .bus_rdata(bus_rdata));

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] keep(input logic [63:0] d, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (i < n) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // scripted bus responder, acting on falling edges
  logic [47:0] script = '0;
  int idx = 0, go_cnt = 0, res_cnt = 0, nak_run = 0, dly = 0;
  logic pend = 1'b0, in_dummy = 1'b0, reiss;
  logic [3:0] pend_kind = '0, last_kind = '0, kind;
  logic [7:0] exp_dp = 8'h4B, last_hs = 8'h00, exp_tok;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_done = 1'b0; pend = 1'b0; exp_dp = 8'h4B; last_hs = 8'h00;
      nak_run = 0; in_dummy = 1'b0; last_kind = '0;
    end else begin
      bus_done = 1'b0;
      if (res_valid) res_cnt++;
      if (pend) begin
        if (dly == 0) begin
          pend = 1'b0; bus_done = 1'b1; bus_rlen = bus_rlen; bus_rdata = RDATA;
          case (pend_kind)
            4'd0: begin bus_err = 1'b0; bus_err_code = 3'd0; bus_hs_pid = 8'hD2; end
            4'd1: begin bus_err = 1'b0; bus_err_code = 3'd0; bus_hs_pid = 8'h5A; end
            4'd2: begin bus_err = 1'b1; bus_err_code = 3'd1; bus_hs_pid = 8'h00; end
            default: begin bus_err = 1'b1; bus_err_code = 3'd5; bus_hs_pid = 8'h00; end
          endcase
          last_kind = pend_kind; last_hs = bus_hs_pid;
          if (pend_kind == 4'd1) nak_run++; else nak_run = 0;
        end else dly--;
      end
      if (bus_go) begin
        reiss = (nak_run == 1 || nak_run == 2);
        if (c_op == 2'd2) exp_dp = 8'hC3;
        else if (!reiss) exp_dp = exp_dp ^ 8'h88;
        chk("R11 handshake byte", {40'h0, bus_pid[23:16]}, {56'h0, (c_op == 2'd2 && !reiss) ? 8'h00 : last_hs});
        if (!reiss) begin
          in_dummy = (c_op == 2'd0) && (last_kind == 4'd2 || (in_dummy && last_kind == 4'd3));
          nak_run = 0;
        end
        chk("R3/R5 data pid", {56'h0, bus_pid[15:8]}, {56'h0, exp_dp});
        exp_tok = (c_op == 2'd0) ? 8'hE1 : (c_op == 2'd1) ? 8'h69 : 8'h2D;
        chk("R3 token", {56'h0, bus_pid[7:0]}, {56'h0, exp_tok});
        chk("R3 direction", {63'h0, bus_out}, {63'h0, c_op != 2'd1});
        chk("R4 endpoint", {60'h0, bus_ep}, {60'h0, (c_op == 2'd2) ? 4'd0 : c_ep});
        chk("R11 device", {57'h0, bus_dev}, {57'h0, c_dev});
        if (in_dummy) begin
          chk("R8 dummy length", {60'h0, bus_len}, 64'd8);
          chk("R8 dummy payload", bus_wdata, PAT);
        end else if (c_op == 2'd2) begin
          chk("R4 setup length", {60'h0, bus_len}, 64'd8);
          chk("R4 setup payload", bus_wdata, c_wdata);
        end else begin
          chk("R11 length", {60'h0, bus_len}, {60'h0, c_len});
          if (c_op == 2'd0) chk("R11 packing", bus_wdata, keep(c_wdata, int'(c_len)));
        end
        kind = (idx < 12) ? script[4*idx +: 4] : 4'd0;
        idx++; go_cnt++;
        if (kind != 4'd4) begin pend = 1'b1; dly = 2; pend_kind = kind; end
      end
    end
  end

  task automatic run(input logic [1:0] op, input logic [3:0] len, input logic [3:0] rlen,
                     input logic [47:0] scr, input logic [7:0] est, input int egos,
                     input logic [63:0] wd, input string tag);
    int n = 0;
    logic [63:0] edat;
    @(negedge clk);
    script = scr; idx = 0; go_cnt = 0; res_cnt = 0; last_kind = '0; in_dummy = 1'b0;
    nak_run = 0; bus_rlen = rlen; c_op = op; c_len = len; c_wdata = wd;
    c_dev = 7'd127 - 7'(len); c_ep = 4'd15 - len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!res_valid && n < 500) begin @(negedge clk); n++; end
    chk({tag, " result arrives"}, {63'h0, res_valid}, 64'd1);
    chk({tag, " status"}, {56'h0, res_status}, {56'h0, est});
    chk({tag, " go count"}, 64'(go_cnt), 64'(egos));
    edat = (op == 2'd1 && !est[7]) ? keep(RDATA, (rlen < len) ? int'(rlen) : int'(len)) : 64'h0;
    chk({tag, " data"}, res_data, edat);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {63'h0, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle busy", {63'h0, busy}, 64'd0);
    chk("R1 idle res_valid", {63'h0, res_valid}, 64'd0);
    chk("R1 idle unsafe", {63'h0, unsafe}, 64'd0);
    chk("R1 idle bus_go", {63'h0, bus_go}, 64'd0);

    // table walk (R2 R3 R4 R5 R7 R8 R9)
    for (int v = 0; v < NV; v++)
      run(VEC[v][69:68], VEC[v][67:64], VEC[v][63:60], VEC[v][59:12], VEC[v][11:4],
          int'(VEC[v][3:0]), 64'h0123_4567_89AB_CDEF ^ {8{8'(v)}}, $sformatf("R9 vec%0d", v));

    // R10: start while busy is ignored, one result pulse
    @(negedge clk);
    script = 48'h01; idx = 0; go_cnt = 0; res_cnt = 0; last_kind = '0; in_dummy = 1'b0;
    nak_run = 0; c_op = 2'd0; c_len = 4'd2; c_wdata = 64'hFFEE; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); chk("R10 busy during command", {63'h0, busy}, 64'd1); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!res_valid) @(negedge clk);
    chk("R10 status", {56'h0, res_status}, 64'h02);
    @(negedge clk);
    chk("R10 pulse width", {63'h0, res_valid}, 64'd0);
    repeat (10) @(negedge clk);
    chk("R10 single result", 64'(res_cnt), 64'd1);
    chk("R10 single transaction", 64'(go_cnt), 64'd2);

    // R6: timeout, sticky unsafe, refusal
    run(2'd0, 4'd3, 4'd0, 48'h4, 8'hFD, 1, 64'h55, "R6 timeout");
    @(negedge clk);
    chk("R6 unsafe set", {63'h0, unsafe}, 64'd1);
    run(2'd1, 4'd2, 4'd2, 48'h0, 8'hFE, 0, 64'h0, "R6 refused");
    chk("R6 unsafe held", {63'h0, unsafe}, 64'd1);

    // R1: reset clears unsafe, first toggle yields DATA0 (checked in responder)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 unsafe cleared", {63'h0, unsafe}, 64'd0);
    run(2'd0, 4'd8, 4'd0, 48'h0, 8'h08, 1, 64'hDEAD_BEEF_0BAD_F00D, "R1 first after reset");
    repeat (4) @(negedge clk);
    summary();
  end
endmodule